// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

This block gathers interrupt requests for a multiprocessor system and routes them to one interrupt line per CPU. Device interrupt sources are kept in one shared pending vector that a sideband sets or clears bit by bit. The interrupt number on the sideband picks the bit. Each CPU has its own enable mask over that vector. The masked product is that CPU's device view, so one device request can reach any subset of CPUs.

Two small per-CPU vectors sit beside the device path. One holds inter-processor interrupts and the other holds interval-timer interrupts. Each bit of these vectors belongs to one CPU. A set path and a clear path drive each vector from sidebands, and software can also clear bits by writing 1s over a single-cycle register port. Each CPU's output line is registered. It is the OR of the CPU's masked device bits, its inter-processor bit and its timer bit.

Top module: `irq_router`

## Requirements
- R1: After reset every register reads as zero and every `cpu_irq` bit is low.
- R2: Word addresses 0 to NCPU-1 hold the per-CPU enable masks. A write stores all 64 bits, and a read returns them.
- R3: When `dev_post` is high, bit `dev_post_num` (a 6-bit index, bit 0 is the LSB) of the shared pending vector is set. When `dev_clr` is high, bit `dev_clr_num` is cleared. The vector reads at word address 2*NCPU (8 by default).
- R4: If a post and a clear name the same bit in one cycle, the bit ends up clear. If they name different bits, both take effect.
- R5: Word address NCPU+i (4 to 7 by default) reads the pending vector ANDed with CPU i's mask. Writes to these addresses and to the pending vector address change nothing.
- R6: `ipi_req` sets, and `ipi_clr` clears, the inter-processor bit of each selected CPU, with bit i standing for CPU i. The vector reads at address 2*NCPU+1 (9). A write there clears the bits written as 1, and bits written as 0 are unchanged.
- R7: `tmr_post` sets the timer bit of every CPU at once. `tmr_clr` clears the selected CPUs' bits. The vector reads at address 2*NCPU+2 (10), and a write there clears the bits written as 1.
- R8: On the inter-processor and timer vectors, a clear from a sideband or a register write wins over a set of the same bit in the same cycle.
- R9: `cpu_irq[i]` equals the OR of CPU i's masked device bits, its inter-processor bit and its timer bit, taken from the state one clock earlier.
- R10: `reg_rdata` is registered and shows the addressed register one cycle after the address is presented. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Word address |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Registered read data |
| dev_post | input | 1 | Set one device pending bit |
| dev_post_num | input | IW | Index of bit to set |
| dev_clr | input | 1 | Clear one device pending bit |
| dev_clr_num | input | IW | Index of bit to clear |
| ipi_req | input | NCPU | CPUs to receive an inter-processor interrupt |
| ipi_clr | input | NCPU | CPUs whose inter-processor bit clears |
| tmr_post | input | 1 | Raise the timer interrupt on all CPUs |
| tmr_clr | input | NCPU | CPUs whose timer bit clears |
| cpu_irq | output | NCPU | Registered interrupt line per CPU |

## Verification
Setting and clearing can land on the same state in one cycle. This happens with a device post and a device clear on the same bit, and with a set and a clear on the same CPU's inter-processor or timer bit. The bench drives such pairs in a single cycle, with the clear coming either from a sideband or from a write-1 register access. It then reads the vector back and compares the value with a model in which the clear is applied last. Pairs that name different bits are driven as well, to show that both operations take effect.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  function automatic int dev_base(input int ncpu);
    return ncpu;
  endfunction
  function automatic int raw_addr(input int ncpu);
    return 2 * ncpu;
  endfunction
  function automatic int ipi_addr(input int ncpu);
    return 2 * ncpu + 1;
  endfunction
  function automatic int tmr_addr(input int ncpu);
    return 2 * ncpu + 2;
  endfunction
  function automatic int addr_width(input int ncpu);
    return $clog2(2 * ncpu + 3);
  endfunction
endpackage

// File: rtl/irq_raw_reg.sv
module irq_raw_reg #(
  parameter int NSRC = 64,
  parameter int IW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            post,
  input  logic [IW-1:0]   post_num,
  input  logic            clr,
  input  logic [IW-1:0]   clr_num,
  output logic [NSRC-1:0] raw_q
);
  logic [NSRC-1:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (post) set_v[post_num] = 1'b1;
    if (clr)  clr_v[clr_num]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= (raw_q | set_v) & ~clr_v;
  end
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_vec) & ~clr_vec;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NCPU = 4,
  parameter int NSRC = 64,
  parameter int AW   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [NSRC-1:0]           wr_data,
  input  logic [NSRC-1:0]           raw_in,
  output logic [NCPU-1:0][NSRC-1:0] mask_q,
  output logic [NCPU-1:0][NSRC-1:0] dev_vec,
  output logic [NCPU-1:0]           dev_any
);
  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic [NSRC-1:0] m_r;
    always_ff @(posedge clk) begin
      if (rst) m_r <= '0;
      else if (wr_en && wr_addr == AW'(i)) m_r <= wr_data;
    end
    assign mask_q[i]  = m_r;
    assign dev_vec[i] = raw_in & m_r;
    assign dev_any[i] = |(raw_in & m_r);
  end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NCPU = 4,
  parameter int NSRC = 64,
  localparam int IW  = $clog2(NSRC),
  localparam int AW  = irq_router_pkg::addr_width(NCPU)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  input  logic            dev_post,
  input  logic [IW-1:0]   dev_post_num,
  input  logic            dev_clr,
  input  logic [IW-1:0]   dev_clr_num,
  input  logic [NCPU-1:0] ipi_req,
  input  logic [NCPU-1:0] ipi_clr,
  input  logic            tmr_post,
  input  logic [NCPU-1:0] tmr_clr,
  output logic [NCPU-1:0] cpu_irq
);
  import irq_router_pkg::*;

  localparam int DEV_BASE = dev_base(NCPU);
  localparam int RAW_ADDR = raw_addr(NCPU);
  localparam int IPI_ADDR = ipi_addr(NCPU);
  localparam int TMR_ADDR = tmr_addr(NCPU);

  logic [NSRC-1:0]           raw_q;
  logic [NCPU-1:0][NSRC-1:0] mask_q;
  logic [NCPU-1:0][NSRC-1:0] dev_vec;
  logic [NCPU-1:0]           dev_any;
  logic [NCPU-1:0]           ipi_q, tmr_q;
  logic [NCPU-1:0]           ipi_wclr, tmr_wclr;
  logic [NSRC-1:0]           rd_next;

  irq_raw_reg #(.NSRC(NSRC), .IW(IW)) u_raw (
    .clk(clk), .rst(rst),
    .post(dev_post), .post_num(dev_post_num),
    .clr(dev_clr), .clr_num(dev_clr_num),
    .raw_q(raw_q)
  );

  irq_mask_bank #(.NCPU(NCPU), .NSRC(NSRC), .AW(AW)) u_mask (
    .clk(clk), .rst(rst),
    .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .raw_in(raw_q), .mask_q(mask_q), .dev_vec(dev_vec), .dev_any(dev_any)
  );

  assign ipi_wclr = (reg_we && reg_addr == AW'(IPI_ADDR)) ? reg_wdata[NCPU-1:0] : '0;
  assign tmr_wclr = (reg_we && reg_addr == AW'(TMR_ADDR)) ? reg_wdata[NCPU-1:0] : '0;

  irq_vec_reg #(.N(NCPU)) u_ipi (
    .clk(clk), .rst(rst),
    .set_vec(ipi_req), .clr_vec(ipi_clr | ipi_wclr), .q(ipi_q)
  );

  irq_vec_reg #(.N(NCPU)) u_tmr (
    .clk(clk), .rst(rst),
    .set_vec({NCPU{tmr_post}}), .clr_vec(tmr_clr | tmr_wclr), .q(tmr_q)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (reg_addr == AW'(i))            rd_next = mask_q[i];
      if (reg_addr == AW'(DEV_BASE + i)) rd_next = dev_vec[i];
    end
    if (reg_addr == AW'(RAW_ADDR)) rd_next = raw_q;
    if (reg_addr == AW'(IPI_ADDR)) rd_next = NSRC'(ipi_q);
    if (reg_addr == AW'(TMR_ADDR)) rd_next = NSRC'(tmr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      cpu_irq   <= '0;
    end else begin
      reg_rdata <= rd_next;
      cpu_irq   <= dev_any | ipi_q | tmr_q;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NCPU = 4,
  parameter int NSRC = 64,
  parameter int IW   = 6,
  parameter int AW   = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      reg_we,
  input logic [AW-1:0]             reg_addr,
  input logic [NSRC-1:0]           reg_rdata,
  input logic                      dev_post,
  input logic [IW-1:0]             dev_post_num,
  input logic                      dev_clr,
  input logic [IW-1:0]             dev_clr_num,
  input logic [NCPU-1:0]           ipi_req,
  input logic [NCPU-1:0]           ipi_clr,
  input logic                      tmr_post,
  input logic [NCPU-1:0]           tmr_clr,
  input logic [NCPU-1:0]           cpu_irq,
  input logic [NSRC-1:0]           raw_q,
  input logic [NCPU-1:0][NSRC-1:0] mask_q,
  input logic [NCPU-1:0]           ipi_q,
  input logic [NCPU-1:0]           tmr_q
);
  localparam int RAW_A = irq_router_pkg::raw_addr(NCPU);
  localparam int IPI_A = irq_router_pkg::ipi_addr(NCPU);
  localparam int TMR_A = irq_router_pkg::tmr_addr(NCPU);

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cpu_irq == '0 && reg_rdata == '0));

  p_post_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (dev_post && !(dev_clr && dev_clr_num == dev_post_num)) |=> raw_q[$past(dev_post_num)]);

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
    dev_clr |=> !raw_q[$past(dev_clr_num)]);

  p_ro_raw_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == AW'(RAW_A) && !dev_post && !dev_clr) |=> $stable(raw_q));

  p_ipi_set_r6: assert property (@(posedge clk) disable iff (rst)
    (!(reg_we && reg_addr == AW'(IPI_A)) && (ipi_req & ~ipi_clr) != '0)
      |=> (ipi_q & $past(ipi_req & ~ipi_clr)) == $past(ipi_req & ~ipi_clr));

  p_tmr_all_r7: assert property (@(posedge clk) disable iff (rst)
    (tmr_post && tmr_clr == '0 && !(reg_we && reg_addr == AW'(TMR_A))) |=> (&tmr_q));

  p_ipi_clr_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (ipi_clr != '0) |=> (ipi_q & $past(ipi_clr)) == '0);

  p_tmr_clr_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (tmr_clr != '0) |=> (tmr_q & $past(tmr_clr)) == '0);

  for (genvar i = 0; i < NCPU; i++) begin : g_out
    p_irq_line_r9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> cpu_irq[i] == $past((|(raw_q & mask_q[i])) | ipi_q[i] | tmr_q[i]));
  end
endmodule

bind irq_router irq_router_chk #(.NCPU(NCPU), .NSRC(NSRC), .IW(IW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .dev_post(dev_post), .dev_post_num(dev_post_num), .dev_clr(dev_clr),
  .dev_clr_num(dev_clr_num), .ipi_req(ipi_req), .ipi_clr(ipi_clr),
  .tmr_post(tmr_post), .tmr_clr(tmr_clr), .cpu_irq(cpu_irq),
  .raw_q(raw_q), .mask_q(mask_q), .ipi_q(ipi_q), .tmr_q(tmr_q)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int NCPU = 4;
  localparam int NSRC = 64;
  localparam int IW   = 6;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_we = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic [NSRC-1:0] reg_wdata = '0;
  logic [NSRC-1:0] reg_rdata;
  logic            dev_post = 1'b0, dev_clr = 1'b0;
  logic [IW-1:0]   dev_post_num = '0, dev_clr_num = '0;
  logic [NCPU-1:0] ipi_req = '0, ipi_clr = '0, tmr_clr = '0;
  logic            tmr_post = 1'b0;
  logic [NCPU-1:0] cpu_irq;

  always #2 clk = ~clk;

  irq_router #(.NCPU(NCPU), .NSRC(NSRC)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_post(dev_post), .dev_post_num(dev_post_num),
    .dev_clr(dev_clr), .dev_clr_num(dev_clr_num),
    .ipi_req(ipi_req), .ipi_clr(ipi_clr),
    .tmr_post(tmr_post), .tmr_clr(tmr_clr), .cpu_irq(cpu_irq)
  );

  typedef struct { logic [NSRC-1:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic rd_issue = 1'b0, rd_pend = 1'b0;

  logic [NSRC-1:0] m_mask [NCPU];
  logic [NSRC-1:0] m_raw = '0;
  logic [NCPU-1:0] m_ipi = '0, m_tmr = '0;

  function automatic logic [NSRC-1:0] model_rd(input int a);
    if (a < NCPU)     return m_mask[a];
    if (a < 2*NCPU)   return m_raw & m_mask[a-NCPU];
    if (a == 2*NCPU)  return m_raw;
    if (a == 2*NCPU+1) return NSRC'(m_ipi);
    if (a == 2*NCPU+2) return NSRC'(m_tmr);
    return '0;
  endfunction

  function automatic logic [NCPU-1:0] model_irq();
    logic [NCPU-1:0] v;
    for (int i = 0; i < NCPU; i++) v[i] = (|(m_raw & m_mask[i])) | m_ipi[i] | m_tmr[i];
    return v;
  endfunction

  // monitor: one registered read result per issued read
  always @(posedge clk) rd_pend <= rd_issue;
  always @(negedge clk) begin
    if (rd_pend && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  // one driven cycle; sets then clears in the model, clear applied last
  task automatic drive(input logic we, input int a, input logic [NSRC-1:0] d,
                       input logic p, input int pn, input logic c, input int cn,
                       input logic [NCPU-1:0] ir, input logic [NCPU-1:0] ic,
                       input logic tp, input logic [NCPU-1:0] tc);
    reg_we = we; reg_addr = AW'(a); reg_wdata = d;
    dev_post = p; dev_post_num = IW'(pn); dev_clr = c; dev_clr_num = IW'(cn);
    ipi_req = ir; ipi_clr = ic; tmr_post = tp; tmr_clr = tc;
    @(negedge clk);
    if (we && a < NCPU) m_mask[a] = d;
    if (p) m_raw[pn] = 1'b1;
    if (c) m_raw[cn] = 1'b0;
    m_ipi = m_ipi | ir;
    if (tp) m_tmr = '1;
    m_ipi = m_ipi & ~ic;
    m_tmr = m_tmr & ~tc;
    if (we && a == 2*NCPU+1) m_ipi = m_ipi & ~d[NCPU-1:0];
    if (we && a == 2*NCPU+2) m_tmr = m_tmr & ~d[NCPU-1:0];
    reg_we = 0; dev_post = 0; dev_clr = 0; ipi_req = '0; ipi_clr = '0;
    tmr_post = 0; tmr_clr = '0;
  endtask

  task automatic wr(input int a, input logic [NSRC-1:0] d);
    drive(1, a, d, 0, 0, 0, 0, '0, '0, 0, '0);
  endtask

  task automatic rd(input int a, input string tag);
    item_t it;
    it.exp = model_rd(a); it.tag = tag;
    sb_q.push_back(it);
    reg_addr = AW'(a); rd_issue = 1'b1;
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    logic [NCPU-1:0] e;
    e = model_irq();
    @(negedge clk);
    checks++;
    if (cpu_irq !== e) begin
      errors++;
      $display("FAIL %s: cpu_irq=%b expected=%b", tag, cpu_irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCPU; i++) m_mask[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R10 unmapped reads
    for (int a = 0; a <= 10; a++) rd(a, "R1 reset read");
    rd(15, "R10 unmapped address");
    chk_irq("R1 reset irq");
    // R2 masks
    wr(0, '1);
    wr(1, 64'h0000_0000_0000_00A5);
    wr(2, 64'h0);
    wr(3, 64'h8000_0000_0000_0000);
    for (int a = 0; a < NCPU; a++) rd(a, "R2 mask readback");
    // R3 post/clear
    drive(0, 0, '0, 1, 0, 0, 0, '0, '0, 0, '0);
    drive(0, 0, '0, 1, 5, 0, 0, '0, '0, 0, '0);
    drive(0, 0, '0, 1, 63, 0, 0, '0, '0, 0, '0);
    rd(8, "R3 raw after posts");
    drive(0, 0, '0, 0, 0, 1, 5, '0, '0, 0, '0);
    rd(8, "R3 raw after clear");
    // R4 collisions
    drive(0, 0, '0, 1, 7, 1, 7, '0, '0, 0, '0);
    rd(8, "R4 same bit clear wins");
    drive(0, 0, '0, 1, 9, 1, 0, '0, '0, 0, '0);
    rd(8, "R4 different bits both apply");
    // R5 masked views, read-only
    for (int a = NCPU; a < 2*NCPU; a++) rd(a, "R5 device view");
    wr(8, 64'hDEAD_BEEF_0000_FFFF);
    wr(5, 64'h1234);
    rd(8, "R5 raw write ignored");
    rd(5, "R5 view write ignored");
    chk_irq("R9 device only");
    // R6 inter-processor
    drive(0, 0, '0, 0, 0, 0, 0, 4'b0110, '0, 0, '0);
    rd(9, "R6 ipi request");
    chk_irq("R9 with ipi");
    wr(9, 64'h2);
    rd(9, "R6 ipi write-1 clear");
    drive(0, 0, '0, 0, 0, 0, 0, '0, 4'b0100, 0, '0);
    rd(9, "R6 ipi sideband clear");
    // R8 set/clear collisions
    drive(0, 0, '0, 0, 0, 0, 0, 4'b0011, 4'b0001, 0, '0);
    drive(1, 9, 64'h8, 0, 0, 0, 0, 4'b1000, '0, 0, '0);
    rd(9, "R8 ipi clear wins");
    // R7 timer
    drive(0, 0, '0, 0, 0, 0, 0, '0, '0, 1, '0);
    rd(10, "R7 timer all cpus");
    chk_irq("R9 with timer");
    drive(0, 0, '0, 0, 0, 0, 0, '0, '0, 0, 4'b0101);
    rd(10, "R7 timer sideband clear");
    wr(10, 64'h8);
    rd(10, "R7 timer write-1 clear");
    drive(0, 0, '0, 0, 0, 0, 0, '0, '0, 1, 4'b0001);
    rd(10, "R8 timer clear wins");
    chk_irq("R9 mixed sources");
    // drain everything
    drive(0, 0, '0, 0, 0, 1, 0, '0, '1, 0, '1);
    drive(0, 0, '0, 0, 0, 1, 9, '0, '0, 0, '0);
    drive(0, 0, '0, 0, 0, 1, 63, '0, '0, 0, '0);
    chk_irq("R9 all quiet");
    rd(8, "R3 raw empty");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule